// File: doc/BRIEF.md
# Boost Regulator Startup and Fault Sequencer

This block is the digital controller that walks a boost regulator from a disabled, isolated state up to steady-state switching. After enable it charges the output linearly in two current steps, then starts switching with a peak current limit that ramps upward, and finally hands over to normal boost operation. All timeouts are measured in ticks of a slow fault clock, presented as single-cycle pulses on `tick_i`, so the analog side can scale the tick rate with input voltage.

Four conditions lead to a timed fault hold-off followed by an automatic retry: both precharge stages expiring, soft-start failing to reach 90% of the setpoint, sustained current limiting, and output collapse. Over-temperature parks the regulator until the flag clears, then resumes at soft-start. A missing rectifier diode latches the block off until the rail voltages fall below their release thresholds or enable is taken low. Comparators, current sources and the pulse modulator sit outside this block and reach it only as flags.

Top module: `boost_seq_ctrl`

## Requirements
- R1: While `en_i` is low the state code is 0 (off) on the clock after it is sampled, whatever the other inputs, with `iso_o`=1, `sw_en_o`=0 and `ilim_code_o`=0.
- R2: From off, with `en_i` high and `uvlo_i` low, the next state is 1 (first precharge) with `pre_hi_o`=0 and `iso_o`=0. While `uvlo_i` is high the block stays off.
- R3: In state 1, `near_in_i` high moves to state 3 (soft-start). Without it, the 16th tick moves to state 2 (second precharge) with `pre_hi_o`=1. In state 2, `near_in_i` high also moves to state 3.
- R4: In state 2 without `near_in_i`, the 64th tick moves to state 5 (fault).
- R5: In state 3, `sw_en_o`=1 and `ilim_code_o` starts at 32 on entry, rises by one per tick, and stays at 63 once reached.
- R6: In state 3, once the code is 63, the 96th further tick moves to state 5 unless `out90_i` has been seen high since entry. `out_reg_i` high moves to state 4 (boost), where `ilim_code_o`=63 and `sw_en_o`=1.
- R7: In state 4, 32 consecutive ticks with `ilim_i` held high move to state 5. Any cycle with `ilim_i` low restarts that count.
- R8: In state 4, `near_in_i` low moves to state 5 on the next clock, with `sw_en_o` dropping to 0.
- R9: In state 5, `sw_en_o`=0 and `iso_o`=1. The 480th tick moves to state 1.
- R10: `otp_i` high in any of states 1 to 5 moves to state 7 (thermal hold, `iso_o`=1, `sw_en_o`=0). When it clears, the next state is 3 with `ilim_code_o`=32.
- R11: With `en_i` high, `diode_miss_i` high moves to state 6 (locked, `iso_o`=1). The block stays there, even after the flag clears, until `rel_ok_i` is high (then state 0) or `en_i` goes low.
- R12: Timeout counts advance only on `tick_i`. Without ticks, no timeout-driven transition occurs however many clocks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| uvlo_i | input | 1 | Input below undervoltage threshold |
| near_in_i | input | 1 | Output at or above input minus 1 V |
| out90_i | input | 1 | Output at or above 90% of setpoint |
| out_reg_i | input | 1 | Output at regulation |
| ilim_i | input | 1 | Peak current limit active |
| otp_i | input | 1 | Over-temperature flag, hysteresis applied outside |
| diode_miss_i | input | 1 | Output rectifier diode missing |
| rel_ok_i | input | 1 | Output and input both below latch release thresholds |
| tick_i | input | 1 | Fault-clock tick, one cycle wide |
| state_o | output | 3 | State code (0 off, 1 pre1, 2 pre2, 3 soft, 4 boost, 5 fault, 6 locked, 7 thermal) |
| pre_hi_o | output | 1 | Precharge current select, 1 = higher level |
| ilim_code_o | output | 6 | Soft-start peak current limit code |
| sw_en_o | output | 1 | Switching enable |
| iso_o | output | 1 | Input-to-output path disconnected |

## Verification
The assertions check the per-cycle relations on every clock. They confirm that enable low forces off, that a precharge step or a restart after a fault only happens on a tick, that the limit code moves by at most one per clock and never drops below half scale, that collapse and thermal release go to the right state, that the lock holds, and that the timer stays still without a tick. Only the bench scenarios can show the exact tick counts: 16, 64, 96 after the ramp, 32 consecutive, and 480. The same holds for the restart of the current-limit count on a gap, for the effect of a seen 90% flag, and for release of the lock both ways.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_PRE1 = 3'd1,
        ST_PRE2 = 3'd2,
        ST_SOFT = 3'd3,
        ST_RUN  = 3'd4,
        ST_HOLD = 3'd5,
        ST_LOCK = 3'd6,
        ST_HOT  = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       seen90;
    } seq_fsm_t;

endpackage

// File: rtl/boost_seq_timer.sv
module boost_seq_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (tick_i && (cnt_q != '1))
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R12: count moves only on a tick
    p_cnt_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/boost_seq_ramp.sv
module boost_seq_ramp #(
    parameter int LIM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    output logic [LIM_W-1:0] code_o,
    output logic             full_o
);

    localparam logic [LIM_W-1:0] FLOOR = LIM_W'(1) << (LIM_W - 1);
    localparam logic [LIM_W-1:0] TOP   = '1;

    logic [LIM_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (load_i)
            code_d = FLOOR;
        else if (step_i && (code_q != TOP))
            code_d = code_q + LIM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= FLOOR;
        else        code_q <= code_d;
    end

    assign code_o = code_q;
    assign full_o = (code_q == TOP);

    // R5: the ramp never falls below half scale
    p_code_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_q >= FLOOR);

endmodule

// File: rtl/boost_seq_ctrl.sv
module boost_seq_ctrl
    import boost_seq_pkg::*;
#(
    parameter int PRE1_TICKS = 16,
    parameter int PRE2_TICKS = 64,
    parameter int SOFT_TICKS = 96,
    parameter int ILIM_TICKS = 32,
    parameter int HOLD_TICKS = 480,
    parameter int LIM_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             uvlo_i,
    input  logic             near_in_i,
    input  logic             out90_i,
    input  logic             out_reg_i,
    input  logic             ilim_i,
    input  logic             otp_i,
    input  logic             diode_miss_i,
    input  logic             rel_ok_i,
    input  logic             tick_i,
    output logic [2:0]       state_o,
    output logic             pre_hi_o,
    output logic [LIM_W-1:0] ilim_code_o,
    output logic             sw_en_o,
    output logic             iso_o
);

    localparam int MAX_A = (PRE1_TICKS > PRE2_TICKS) ? PRE1_TICKS : PRE2_TICKS;
    localparam int MAX_B = (SOFT_TICKS > ILIM_TICKS) ? SOFT_TICKS : ILIM_TICKS;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > HOLD_TICKS) ? MAX_C : HOLD_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0] PRE1_LAST = CNT_W'(PRE1_TICKS - 1);
    localparam logic [CNT_W-1:0] PRE2_LAST = CNT_W'(PRE2_TICKS - 1);
    localparam logic [CNT_W-1:0] SOFT_LAST = CNT_W'(SOFT_TICKS - 1);
    localparam logic [CNT_W-1:0] ILIM_LAST = CNT_W'(ILIM_TICKS - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

    seq_fsm_t         fsm_d, fsm_q;
    logic [CNT_W-1:0] cnt;
    logic [LIM_W-1:0] lim_code;
    logic             lim_full;
    logic             entry;
    logic             cnt_clr;
    logic             ramp_load;
    logic             ramp_step;
    logic             active;

    assign active = (fsm_q.st inside {ST_PRE1, ST_PRE2, ST_SOFT, ST_RUN, ST_HOLD});

    always_comb begin
        fsm_d = fsm_q;
        if (!en_i) begin
            fsm_d.st = ST_OFF;
        end else if (diode_miss_i) begin
            fsm_d.st = ST_LOCK;
        end else if (otp_i && active) begin
            fsm_d.st = ST_HOT;
        end else begin
            unique case (fsm_q.st)
                ST_OFF:
                    if (!uvlo_i) fsm_d.st = ST_PRE1;
                ST_PRE1:
                    if (near_in_i)                             fsm_d.st = ST_SOFT;
                    else if (tick_i && (cnt == PRE1_LAST))     fsm_d.st = ST_PRE2;
                ST_PRE2:
                    if (near_in_i)                             fsm_d.st = ST_SOFT;
                    else if (tick_i && (cnt == PRE2_LAST))     fsm_d.st = ST_HOLD;
                ST_SOFT:
                    if (out_reg_i)                             fsm_d.st = ST_RUN;
                    else if (tick_i && lim_full && !fsm_q.seen90 && (cnt == SOFT_LAST))
                                                               fsm_d.st = ST_HOLD;
                ST_RUN:
                    if (!near_in_i)                            fsm_d.st = ST_HOLD;
                    else if (tick_i && ilim_i && (cnt == ILIM_LAST))
                                                               fsm_d.st = ST_HOLD;
                ST_HOLD:
                    if (tick_i && (cnt == HOLD_LAST))          fsm_d.st = ST_PRE1;
                ST_LOCK:
                    if (rel_ok_i)                              fsm_d.st = ST_OFF;
                ST_HOT:
                    if (!otp_i)                                fsm_d.st = ST_SOFT;
                default:                                       fsm_d.st = ST_OFF;
            endcase
        end

        entry = (fsm_d.st != fsm_q.st);
        if (entry)
            fsm_d.seen90 = 1'b0;
        else if ((fsm_q.st == ST_SOFT) && out90_i)
            fsm_d.seen90 = 1'b1;

        cnt_clr   = entry
                  || ((fsm_q.st == ST_RUN)  && !ilim_i)
                  || ((fsm_q.st == ST_SOFT) && !lim_full);
        ramp_load = entry && (fsm_d.st == ST_SOFT);
        ramp_step = tick_i && (fsm_q.st == ST_SOFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st     <= ST_OFF;
            fsm_q.seen90 <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    boost_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .tick_i (tick_i),
        .cnt_o  (cnt)
    );

    boost_seq_ramp #(.LIM_W(LIM_W)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ramp_load),
        .step_i (ramp_step),
        .code_o (lim_code),
        .full_o (lim_full)
    );

    assign state_o     = fsm_q.st;
    assign pre_hi_o    = (fsm_q.st == ST_PRE2);
    assign sw_en_o     = (fsm_q.st == ST_SOFT) || (fsm_q.st == ST_RUN);
    assign iso_o       = !(fsm_q.st inside {ST_PRE1, ST_PRE2, ST_SOFT, ST_RUN});
    assign ilim_code_o = (fsm_q.st == ST_SOFT) ? lim_code :
                         (fsm_q.st == ST_RUN)  ? '1       : '0;

    // R1: enable low wins over every other input
    p_off_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (fsm_q.st == ST_OFF));

    // R3: the step to the second precharge stage happens only on a tick
    p_pre2_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_PRE2) && ($past(fsm_q.st) == ST_PRE1)) |-> $past(tick_i));

    // R5: the limit code moves by at most one step per clock in soft-start
    p_soft_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_SOFT) && ($past(fsm_q.st) == ST_SOFT)) |->
        ((lim_code == $past(lim_code)) || (lim_code == ($past(lim_code) + LIM_W'(1)))));

    // R8: output collapse in boost leads straight to the fault state
    p_collapse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_RUN) && en_i && !diode_miss_i && !otp_i && !near_in_i)
        |=> (fsm_q.st == ST_HOLD));

    // R9: retry after the hold-off only on a tick
    p_hold_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_PRE1) && ($past(fsm_q.st) == ST_HOLD)) |-> $past(tick_i));

    // R10: thermal release resumes at soft-start
    p_hot_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_HOT) && en_i && !diode_miss_i && !otp_i)
        |=> (fsm_q.st == ST_SOFT));

    // R11: the lock holds until release or enable low
    p_lock_stay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == ST_LOCK) && en_i && !rel_ok_i) |=> (fsm_q.st == ST_LOCK));

endmodule

// File: tb/tb_boost_seq_ctrl.sv
module tb_boost_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 0, uvlo_i = 0, near_in_i = 0, out90_i = 0, out_reg_i = 0;
    logic       ilim_i = 0, otp_i = 0, diode_miss_i = 0, rel_ok_i = 0, tick_i = 0;
    logic [2:0] state_o;
    logic       pre_hi_o, sw_en_o, iso_o;
    logic [5:0] ilim_code_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    boost_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
        .near_in_i(near_in_i), .out90_i(out90_i), .out_reg_i(out_reg_i),
        .ilim_i(ilim_i), .otp_i(otp_i), .diode_miss_i(diode_miss_i),
        .rel_ok_i(rel_ok_i), .tick_i(tick_i), .state_o(state_o),
        .pre_hi_o(pre_hi_o), .ilim_code_o(ilim_code_o), .sw_en_o(sw_en_o),
        .iso_o(iso_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic quiet_inputs();
        ilim_i = 0; otp_i = 0; diode_miss_i = 0; rel_ok_i = 0; out90_i = 0;
    endtask

    task automatic go_soft();
        quiet_inputs();
        en_i = 0; step(1);
        en_i = 1; uvlo_i = 0; near_in_i = 1; out_reg_i = 0;
        step(2);
        chk("R3 soft entry", state_o, 3);
    endtask

    task automatic go_run();
        go_soft();
        out_reg_i = 1; step(1);
        chk("R6 boost entry", state_o, 4);
    endtask

    task automatic t_reset();
        chk("R1 reset state", state_o, 0);
        chk("R1 reset iso", iso_o, 1);
        chk("R1 reset sw", sw_en_o, 0);
        chk("R1 reset code", ilim_code_o, 0);
    endtask

    task automatic t_start();
        uvlo_i = 1; en_i = 1; step(3);
        chk("R2 uvlo blocks", state_o, 0);
        uvlo_i = 0; step(1);
        chk("R2 pre1 state", state_o, 1);
        chk("R2 pre1 low level", pre_hi_o, 0);
        chk("R2 pre1 connected", iso_o, 0);
    endtask

    task automatic t_precharge();
        step(50);
        chk("R12 no tick no timeout", state_o, 1);
        ticks(15);
        chk("R3 pre1 after 15", state_o, 1);
        ticks(1);
        chk("R3 pre2 after 16", state_o, 2);
        chk("R3 pre2 high level", pre_hi_o, 1);
        ticks(63);
        chk("R4 pre2 after 63", state_o, 2);
        ticks(1);
        chk("R4 fault after 64", state_o, 5);
        chk("R9 fault iso", iso_o, 1);
        chk("R9 fault sw", sw_en_o, 0);
    endtask

    task automatic t_hold();
        ticks(479);
        chk("R9 hold after 479", state_o, 5);
        ticks(1);
        chk("R9 retry after 480", state_o, 1);
    endtask

    task automatic t_soft_ramp();
        go_soft();
        chk("R5 sw on", sw_en_o, 1);
        chk("R5 start code", ilim_code_o, 32);
        ticks(5);
        chk("R5 code after 5", ilim_code_o, 37);
        ticks(26);
        chk("R5 code at top", ilim_code_o, 63);
        ticks(3);
        chk("R5 code saturates", ilim_code_o, 63);
        ticks(92);
        chk("R6 soft after 95 at top", state_o, 3);
        ticks(1);
        chk("R6 soft timeout", state_o, 5);
    endtask

    task automatic t_soft_90();
        go_soft();
        out90_i = 1; step(1); out90_i = 0;
        ticks(140);
        chk("R6 seen90 no timeout", state_o, 3);
        out_reg_i = 1; step(1);
        chk("R6 boost state", state_o, 4);
        chk("R6 boost code", ilim_code_o, 63);
        chk("R6 boost sw", sw_en_o, 1);
    endtask

    task automatic t_ilim();
        go_run();
        ilim_i = 1; ticks(31);
        chk("R7 ilim 31", state_o, 4);
        ticks(1);
        chk("R7 ilim 32 fault", state_o, 5);
        go_run();
        ilim_i = 1; ticks(20);
        ilim_i = 0; step(1);
        ilim_i = 1; ticks(20);
        chk("R7 gap restarts count", state_o, 4);
        ticks(11);
        chk("R7 after 31 since gap", state_o, 4);
        ticks(1);
        chk("R7 32 since gap", state_o, 5);
        ilim_i = 0;
    endtask

    task automatic t_collapse();
        go_run();
        near_in_i = 0; step(1);
        chk("R8 collapse fault", state_o, 5);
        chk("R8 sw off", sw_en_o, 0);
        near_in_i = 1;
    endtask

    task automatic t_otp();
        go_run();
        otp_i = 1; step(1);
        chk("R10 hot state", state_o, 7);
        chk("R10 hot iso", iso_o, 1);
        chk("R10 hot sw", sw_en_o, 0);
        step(5);
        chk("R10 hot held", state_o, 7);
        otp_i = 0; out_reg_i = 0; step(1);
        chk("R10 resume soft", state_o, 3);
        chk("R10 resume code", ilim_code_o, 32);
    endtask

    task automatic t_diode();
        go_run();
        diode_miss_i = 1; step(1);
        chk("R11 lock state", state_o, 6);
        chk("R11 lock iso", iso_o, 1);
        diode_miss_i = 0; step(10);
        chk("R11 lock sticky", state_o, 6);
        rel_ok_i = 1; step(1);
        chk("R11 release off", state_o, 0);
        rel_ok_i = 0; step(1);
        chk("R11 restart pre1", state_o, 1);
        diode_miss_i = 1; step(1);
        chk("R11 relock", state_o, 6);
        diode_miss_i = 0; en_i = 0; step(1);
        chk("R11 enable low releases", state_o, 0);
    endtask

    task automatic t_shutdown();
        go_run();
        en_i = 0; otp_i = 1; step(1);
        chk("R1 off state", state_o, 0);
        chk("R1 off iso", iso_o, 1);
        chk("R1 off sw", sw_en_o, 0);
        chk("R1 off code", ilim_code_o, 0);
        step(3);
        chk("R1 priority over otp", state_o, 0);
        otp_i = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_start();
        t_precharge();
        t_hold();
        t_soft_ramp();
        t_soft_90();
        t_ilim();
        t_collapse();
        t_otp();
        t_diode();
        t_shutdown();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule